// File: doc/BRIEF.md
# Cell Parity Error Monitor

This block watches the data path that carries fixed-length cells in from a user-side interface. On every valid beat it checks one parity bit against the data. In narrow mode the check covers the low byte of the bus. In wide mode it covers the whole 16-bit word. A configuration input selects odd or even parity. Each mismatch produces a one-cycle parity event. Each event increments an error counter that stops at its all-ones value and returns to zero when it is read.

The parity event and five single-cycle event pulses from neighbouring cell-path logic each set a bit in a status register. A status read clears that register. A separate read/write enable register decides which of those status bits pull the active-low interrupt output down. Software reaches all three registers through a simple port with a strobe and an address. The read data is combinational in the strobe cycle, and any clear-on-read takes effect at the clock edge that ends that cycle.

The block is a datapath plus a small register bank. It has no state machine.

Top module: `cellpar_mon`

## Requirements
- R1: When `in_vld` is high, the check covers `in_word[7:0]` with `in_par` while `wide_mode` is 0, and all 16 bits of `in_word` with `in_par` while `wide_mode` is 1. In narrow mode the upper byte is ignored. Beats with `in_vld` low are never checked.
- R2: With `cfg_even` at 0 (odd parity), a beat is good when the checked bits plus `in_par` hold an odd number of ones. With `cfg_even` at 1 (even parity), that count must be even.
- R3: The error counter is `CNT_W` bits wide (default 32). It is zero after reset and rises by exactly one for each erroneous beat.
- R4: At all-ones the counter holds its value on further errors until it is read.
- R5: Reading address 2 returns the counter value on `reg_rdata` in the strobe cycle and leaves the counter at zero afterwards. An error in that same cycle leaves it at 1.
- R6: The status register sits at address 0. Its bits are: bit 0 parity error, bit 1 `ext_evt[0]` (HEC error), bit 2 `ext_evt[1]` (insertion buffer overflow), bit 3 `ext_evt[2]` (extraction buffer overflow), bit 4 `ext_evt[3]` (cell inserted) and bit 5 `ext_evt[4]` (cell extracted). Bits 7:6 and all higher read bits are zero. An event sets its bit whether or not that bit is enabled.
- R7: A status read clears every status bit, except that a bit whose event arrives in the read cycle stays set.
- R8: The enable register sits at address 1. It is read/write, zero after reset, and stores only bits 5:0, so bits 7:6 read as zero. Address 3 reads as zero.
- R9: `int_n` is low while any status bit and its matching enable bit are both set, and high otherwise. This includes the state after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_word | input | 16 | Cell data bus |
| in_par | input | 1 | Parity bit for the current beat |
| in_vld | input | 1 | Beat valid strobe |
| wide_mode | input | 1 | 0: check low byte, 1: check full 16-bit word |
| cfg_even | input | 1 | 0: odd parity, 1: even parity |
| ext_evt | input | 5 | Single-cycle event pulses from other cell-path logic |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | CNT_W | Register read data, valid while `reg_rd` is high |
| int_n | output | 1 | Active-low interrupt |

## Verification
The checker assumes that the inputs are synchronous to `clk` and that each read or write strobe lasts a single cycle. It also assumes that `reg_rd` and `reg_wr` are never high together, and that `reg_addr` stays steady while a strobe is high. The bench drives all inputs one time step after a rising edge and raises at most one register strobe per cycle. It overlaps a read with a data beat or event pulse only in the cases meant to exercise the same-cycle rules. It builds the block with `CNT_W` set to 8, so that saturation is reachable with a few hundred error beats.

// File: rtl/cellpar_pkg.sv
package cellpar_pkg;

    typedef enum logic [1:0] {
        ADDR_STS  = 2'd0,
        ADDR_EN   = 2'd1,
        ADDR_CNT  = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    localparam int NUM_EXT = 5;
    localparam int NUM_SRC = NUM_EXT + 1;
    localparam int REG_W   = 8;

endpackage

// File: rtl/cellpar_chk.sv
module cellpar_chk #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic [DATA_W-1:0] word,
    input  logic              par,
    input  logic              vld,
    input  logic              wide,
    input  logic              even,
    output logic              err
);
    localparam int UPPER_W = DATA_W - NARROW_W;

    logic [DATA_W-1:0] mask;
    logic              data_xor;

    always_comb begin
        mask     = wide ? {DATA_W{1'b1}} : {{UPPER_W{1'b0}}, {NARROW_W{1'b1}}};
        data_xor = ^(word & mask);
        // odd: good when data_xor ^ par == 1; even: good when it is 0
        err      = vld & (data_xor ^ par ^ ~even);
    end
endmodule

// File: rtl/cellpar_cnt.sv
module cellpar_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    logic         sat;
    logic [W-1:0] cnt_nx;

    always_comb begin
        sat = &cnt;
        if (clr)
            cnt_nx = {{(W-1){1'b0}}, inc};
        else if (inc && !sat)
            cnt_nx = cnt + 1'b1;
        else
            cnt_nx = cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else
            cnt <= cnt_nx;
    end
endmodule

// File: rtl/cellpar_irq.sv
module cellpar_irq #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         sts_clr,
    input  logic         en_we,
    input  logic [N-1:0] en_wdata,
    output logic [N-1:0] sts,
    output logic [N-1:0] en,
    output logic         int_n
);
    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sts[i] <= 1'b0;
            else
                sts[i] <= (sts[i] & ~sts_clr) | evt[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en <= '0;
        else if (en_we)
            en <= en_wdata;
    end

    assign int_n = ~|(sts & en);
endmodule

// File: rtl/cellpar_mon.sv
module cellpar_mon
    import cellpar_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:0]      in_word,
    input  logic             in_par,
    input  logic             in_vld,
    input  logic             wide_mode,
    input  logic             cfg_even,
    input  logic [4:0]       ext_evt,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             int_n
);
    localparam int PAD_W = REG_W - NUM_SRC;

    reg_addr_e          addr_e;
    logic               par_evt;
    logic               rd_sts, rd_cnt, wr_en;
    logic [NUM_SRC-1:0] sts, en, src;
    logic [CNT_W-1:0]   cnt;

    assign addr_e = reg_addr_e'(reg_addr);
    assign rd_sts = reg_rd && (addr_e == ADDR_STS);
    assign rd_cnt = reg_rd && (addr_e == ADDR_CNT);
    assign wr_en  = reg_wr && (addr_e == ADDR_EN);
    assign src    = {ext_evt, par_evt};

    cellpar_chk #(.DATA_W(16), .NARROW_W(8)) chk_i (
        .word (in_word),
        .par  (in_par),
        .vld  (in_vld),
        .wide (wide_mode),
        .even (cfg_even),
        .err  (par_evt)
    );

    cellpar_cnt #(.W(CNT_W)) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (par_evt),
        .clr   (rd_cnt),
        .cnt   (cnt)
    );

    cellpar_irq #(.N(NUM_SRC)) irq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (src),
        .sts_clr  (rd_sts),
        .en_we    (wr_en),
        .en_wdata (reg_wdata[NUM_SRC-1:0]),
        .sts      (sts),
        .en       (en),
        .int_n    (int_n)
    );

    always_comb begin
        reg_rdata = '0;
        case (addr_e)
            ADDR_STS: reg_rdata[REG_W-1:0] = {{PAD_W{1'b0}}, sts};
            ADDR_EN:  reg_rdata[REG_W-1:0] = {{PAD_W{1'b0}}, en};
            ADDR_CNT: reg_rdata            = cnt;
            default:  reg_rdata            = '0;
        endcase
    end
endmodule

// File: rtl/cellpar_mon_sva.sv
module cellpar_mon_sva #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_rd,
    input logic [1:0]       reg_addr,
    input logic [CNT_W-1:0] reg_rdata,
    input logic             par_evt,
    input logic [4:0]       ext_evt,
    input logic [5:0]       sts,
    input logic [5:0]       en,
    input logic [CNT_W-1:0] cnt,
    input logic             int_n
);
    logic rd_c, rd_s;
    assign rd_c = reg_rd && (reg_addr == 2'd2);
    assign rd_s = reg_rd && (reg_addr == 2'd0);

    AST_CNT_HOLD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        ((&cnt) && !rd_c) |=> (&cnt)); // R4
    AST_CNT_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_c && !par_evt) |=> (cnt == '0)); // R5
    AST_CNT_READ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_c && par_evt) |=> (cnt == CNT_W'(1))); // R5
    AST_STS_PAR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        par_evt |=> sts[0]); // R6
    AST_STS_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_s && !par_evt && (ext_evt == '0)) |=> (sts == '0)); // R7
    AST_INT_ON_PAR: assert property (@(posedge clk) disable iff (!rst_n)
        (par_evt && en[0]) |=> !int_n); // R9
    AST_RD_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr != 2'd2) |-> (reg_rdata[CNT_W-1:6] == '0)); // R8
endmodule

bind cellpar_mon cellpar_mon_sva #(.CNT_W(CNT_W)) sva_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .par_evt   (par_evt),
    .ext_evt   (ext_evt),
    .sts       (sts),
    .en        (en),
    .cnt       (cnt),
    .int_n     (int_n)
);

// File: tb/cellpar_mon_tb_top.sv
module cellpar_mon_tb_top;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [15:0]   in_word;
    logic          in_par, in_vld, wide_mode, cfg_even;
    logic [4:0]    ext_evt;
    logic          reg_rd, reg_wr;
    logic [1:0]    reg_addr;
    logic [7:0]    reg_wdata;
    logic [CW-1:0] reg_rdata;
    logic          int_n;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [CW-1:0] exp_q[$];
    string         tag_q[$];

    always #5 clk = ~clk;

    cellpar_mon #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_par(in_par),
        .in_vld(in_vld), .wide_mode(wide_mode), .cfg_even(cfg_even),
        .ext_evt(ext_evt), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .int_n(int_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: compares read data in the strobe cycle
    always @(negedge clk) begin
        if (rst_n === 1'b1 && reg_rd === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "SCOREBOARD-EMPTY", int'(reg_rdata), 0);
            end else begin
                automatic logic [CW-1:0] e = exp_q.pop_front();
                automatic string         t = tag_q.pop_front();
                chk(reg_rdata === e, t, int'(reg_rdata), int'(e));
            end
        end
    end

    function automatic logic pgood(input logic [15:0] w);
        pgood = (wide_mode ? ^w : ^w[7:0]) ^ ~cfg_even;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
        in_vld = 0; reg_rd = 0; reg_wr = 0; ext_evt = '0;
    endtask

    task automatic send(input logic [15:0] w, input bit corrupt);
        in_word = w; in_par = pgood(w) ^ corrupt; in_vld = 1;
        tick();
    endtask

    task automatic rd_exp(input logic [1:0] a, input logic [CW-1:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        reg_addr = a; reg_rd = 1;
        tick();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        tick();
    endtask

    initial begin
        #(1_500_000);
        if (!done) begin
            chk(1'b0, "WATCHDOG", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; in_word = '0; in_par = 0; in_vld = 0; wide_mode = 0; cfg_even = 0;
        ext_evt = '0; reg_rd = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // reset state
        chk(int_n === 1'b1, "R9 reset int_n", int'(int_n), 1);
        rd_exp(2'd0, 8'h00, "R6 reset status");
        rd_exp(2'd1, 8'h00, "R8 reset enable");
        rd_exp(2'd2, 8'h00, "R3 reset counter");

        // narrow odd parity: three good beats, two bad
        send(16'h0012, 0); send(16'h0000, 0); send(16'h00FE, 0);
        send(16'h00A5, 1); send(16'h0003, 1);
        chk(int_n === 1'b1, "R9 disabled source", int'(int_n), 1);
        rd_exp(2'd2, 8'd2, "R3 count two errors");
        rd_exp(2'd2, 8'd0, "R5 cleared after read");

        // narrow mode ignores upper byte; invalid beats unchecked
        send(16'hFF12, 0);
        send(16'h8012, 0);
        in_word = 16'h0001; in_par = pgood(16'h0001) ^ 1'b1; in_vld = 0;
        tick();
        rd_exp(2'd2, 8'd0, "R1 upper byte and idle ignored");

        // wide even parity: low byte alone looks fine, whole word does not
        wide_mode = 1; cfg_even = 1;
        in_word = 16'h0100; in_par = 1'b0; in_vld = 1;
        tick();
        send(16'h0F01, 0);
        rd_exp(2'd2, 8'd1, "R2 wide even mismatch");

        // status read and clear
        rd_exp(2'd0, 8'h01, "R6 parity status bit");
        rd_exp(2'd0, 8'h00, "R7 status cleared");

        // enable register and interrupt
        wr(2'd1, 8'hFF);
        rd_exp(2'd1, 8'h3F, "R8 enable upper bits zero");
        chk(int_n === 1'b1, "R9 no status", int'(int_n), 1);
        ext_evt = 5'b00001;
        tick();
        chk(int_n === 1'b0, "R9 enabled event", int'(int_n), 0);
        rd_exp(2'd0, 8'h02, "R6 hec status bit");
        chk(int_n === 1'b1, "R9 released after read", int'(int_n), 1);

        // disabled events still set status
        wr(2'd1, 8'h00);
        ext_evt = 5'b11111;
        tick();
        chk(int_n === 1'b1, "R9 all disabled", int'(int_n), 1);
        rd_exp(2'd0, 8'h3E, "R6 external status bits");

        // event in the read cycle survives
        ext_evt = 5'b10000;
        rd_exp(2'd0, 8'h00, "R7 same cycle read value");
        rd_exp(2'd0, 8'h20, "R7 event kept");

        // error in the counter read cycle
        wide_mode = 0; cfg_even = 0;
        in_word = 16'h0007; in_par = pgood(16'h0007) ^ 1'b1; in_vld = 1;
        rd_exp(2'd2, 8'd0, "R5 same cycle read value");
        rd_exp(2'd2, 8'd1, "R5 error kept");
        rd_exp(2'd0, 8'h01, "R6 parity status again");

        // saturation
        for (int i = 0; i < 300; i++) send(16'(i), 1);
        rd_exp(2'd2, 8'hFF, "R4 saturated");
        rd_exp(2'd2, 8'h00, "R4 cleared from max");
        rd_exp(2'd0, 8'h01, "R6 clear status");

        // enabled parity interrupt
        wr(2'd1, 8'h01);
        send(16'h0055, 1);
        chk(int_n === 1'b0, "R9 parity interrupt", int'(int_n), 0);
        rd_exp(2'd0, 8'h01, "R7 parity read");
        chk(int_n === 1'b1, "R9 parity released", int'(int_n), 1);

        rd_exp(2'd3, 8'h00, "R8 spare address");

        repeat (2) tick();
        chk(exp_q.size() == 0, "SCOREBOARD-LEFT", exp_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule